// File: doc/BRIEF.md
# Programmable Clock Generator Slice

This block is one slice of a clock generation unit. It picks one of several incoming source clocks and derives a divided clock from it. The division runs in one of two modes. The binary mode divides by a power of two. The integer mode divides by the programmed value, with an optional correction that brings odd ratios close to a 50% duty cycle. A configuration write loads the division value, the mode bits, the source select, the level the output holds while stopped, and whether the clock reaches an external pin.

The generator enable is a separate level input, so rewriting the configuration never starts or stops the clock by accident. A new division value takes effect only at the end of the period in progress. When the enable is removed, the slice finishes its current output period and then parks the output at the programmed idle level. A status output stays high until that has happened.

The source select is taken only while the generator is stopped. The source clock mux is a plain registered select and does not switch between asynchronous clocks without glitches.

Top module: `clkgen_slice`

## Requirements
- R1: With the binary mode bit (`cfg_binary_i`) set, the output period is 2^(DIV+1) source cycles with a 50% duty cycle. The exponent saturates at the counter width of 16.
- R2: With the binary mode bit clear and DIV of 2 or more, the output period is DIV source cycles. With balancing off, the high phase lasts floor(DIV/2) source cycles.
- R3: With the binary mode bit clear and DIV equal to 0 or 1, the selected source clock passes to the output undivided.
- R4: With balancing (`cfg_balance_i`) set and an odd integer DIV of 3 or more, the high phase lasts DIV/2 source cycles, a half-cycle resolution obtained with a falling-edge register. Even divisors are unaffected.
- R5: While the generator is stopped, `gclk_o` rests at the level of the idle-level bit (`cfg_idle_hi_i`). After reset, the status is 0, `gclk_o` is 0 and `pin_o` is 0.
- R6: After `gen_en_i` falls, the output completes the period in progress. `en_stat_o` stays 1 until the output has stopped at that period boundary, and it falls only after the enable has been sampled low.
- R7: A configuration write while the generator runs leaves the generator running. The enable is held only by `gen_en_i`.
- R8: A DIV value written while running takes effect at the next output period boundary. The period in progress keeps the old length.
- R9: `pin_o` carries `gclk_o` when the pin-enable bit is 1 and is held at 0 when that bit is 0.
- R10: `cfg_src_i` selects the source clock by index (0 = bit 0 of `src_clk_i`). The selection is applied while the generator is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk_i | input | NUM_SRC | Candidate source clocks |
| rst_i | input | 1 | Synchronous active-high reset, in the selected source domain |
| cfg_wr_i | input | 1 | Loads all configuration fields below in one cycle |
| cfg_src_i | input | SRC_W | Source clock index |
| cfg_div_i | input | 8 | Division value DIV |
| cfg_binary_i | input | 1 | 1 = power-of-two mode, 0 = integer mode |
| cfg_balance_i | input | 1 | Duty balancing for odd integer divisors |
| cfg_idle_hi_i | input | 1 | Output level while stopped |
| cfg_pin_en_i | input | 1 | Routes the clock to `pin_o` |
| gen_en_i | input | 1 | Generator enable level |
| gclk_o | output | 1 | Generated clock |
| pin_o | output | 1 | Gated copy of the clock for an external pin |
| en_stat_o | output | 1 | 1 while the generator is still producing clock |

## Verification
The bench measures real periods and high times with timestamps, so the tests cover the odd balanced ratios and the passthrough cases where edges land on falling source edges. A design that loses the half cycle would show a high time off by T/2. A design that divides by one in passthrough would show twice the period.

Stopping is timed from the last rising output edge to the fall of the status. A design that stops at once would leave a runt and report stopped too early.

A DIV rewrite in mid-period must leave that period at its old length. A design that loads the new value at once would give a wrong intermediate period. A design that cleared the enable on the write would halt the clock.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

    localparam int DIV_W = 8;
    localparam int CNT_W = 16;

    // configuration word as loaded by a write
    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             binary;
        logic             balance;
        logic             idle_hi;
        logic             pin_en;
    } gen_cfg_t;

    // what the counter needs for one output period
    typedef struct packed {
        logic [CNT_W-1:0] last;     // final phase index of a period
        logic [CNT_W-1:0] high;     // phases with the rising-edge wave high
        logic             pass;     // undivided passthrough
        logic             odd_fix;  // merge with the falling-edge copy
    } div_plan_t;

    function automatic div_plan_t plan_of(gen_cfg_t c);
        div_plan_t        p;
        logic [CNT_W:0]   full;
        logic [CNT_W-1:0] n;
        int               e;
        p    = '0;
        full = '0;
        n    = '0;
        if (c.binary) begin
            e = int'(c.div) + 1;
            if (e > CNT_W) e = CNT_W;
            full[e] = 1'b1;
            p.last  = CNT_W'(full - 1'b1);
            p.high  = full[CNT_W:1];
        end else begin
            n         = (c.div < DIV_W'(2)) ? CNT_W'(1) : CNT_W'(c.div);
            p.last    = n - 1'b1;
            p.pass    = (n == CNT_W'(1));
            p.odd_fix = c.balance & n[0] & (n > CNT_W'(1));
            p.high    = p.odd_fix ? ((n + 1'b1) >> 1) : (n >> 1);
        end
        return p;
    endfunction

endpackage

// File: rtl/clkgen_src_mux.sv
module clkgen_src_mux #(
    parameter int NUM_SRC = 2,
    parameter int SRC_W   = 1
) (
    input  logic [NUM_SRC-1:0] src_clk_i,
    input  logic [SRC_W-1:0]   sel_i,
    output logic               gen_clk_o
);

    generate
        if (NUM_SRC == (1 << SRC_W)) begin : g_full
            assign gen_clk_o = src_clk_i[sel_i];
        end else begin : g_guard
            // indices beyond the last source fall back to source 0
            logic in_range;
            assign in_range  = ({1'b0, sel_i} < (SRC_W + 1)'(NUM_SRC));
            assign gen_clk_o = in_range ? src_clk_i[sel_i] : src_clk_i[0];
        end
    endgenerate

endmodule

// File: rtl/clkgen_div_core.sv
module clkgen_div_core
    import clkgen_pkg::*;
(
    input  logic             gen_clk,
    input  logic             rst_i,
    input  logic             en_i,
    input  div_plan_t        plan_new_i,
    output logic             running_o,
    output logic             q_p_o,
    output div_plan_t        plan_o,
    output logic [CNT_W-1:0] cnt_o
);

    logic             running_q;
    logic             q_p_q;
    div_plan_t        plan_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;
    logic             at_end;

    assign cnt_inc = cnt_q + 1'b1;
    assign at_end  = (cnt_q == plan_q.last);

    always_ff @(posedge gen_clk) begin
        if (rst_i) begin
            running_q <= 1'b0;
            q_p_q     <= 1'b0;
            cnt_q     <= '0;
            plan_q    <= '0;
        end else if (!running_q) begin
            if (en_i) begin
                running_q <= 1'b1;
                plan_q    <= plan_new_i;
                cnt_q     <= '0;
                q_p_q     <= (plan_new_i.high != '0);
            end
        end else if (at_end) begin
            cnt_q <= '0;
            if (!en_i) begin
                running_q <= 1'b0;
                q_p_q     <= 1'b0;
            end else begin
                plan_q <= plan_new_i;
                q_p_q  <= (plan_new_i.high != '0);
            end
        end else begin
            cnt_q <= cnt_inc;
            q_p_q <= (cnt_inc < plan_q.high);
        end
    end

    assign running_o = running_q;
    assign q_p_o     = q_p_q;
    assign plan_o    = plan_q;
    assign cnt_o     = cnt_q;

endmodule

// File: rtl/clkgen_shaper.sv
module clkgen_shaper (
    input  logic gen_clk,
    input  logic rst_i,
    input  logic running_i,
    input  logic q_p_i,
    input  logic pass_i,
    input  logic odd_fix_i,
    input  logic idle_hi_i,
    output logic wave_o,
    output logic status_o
);

    logic q_n_q;
    logic live_n_q;
    logic div_wave;

    // falling-edge helpers: half-cycle copy and passthrough gate
    always_ff @(negedge gen_clk) begin
        if (rst_i) begin
            q_n_q    <= 1'b0;
            live_n_q <= 1'b0;
        end else begin
            q_n_q    <= q_p_i;
            live_n_q <= running_i & pass_i;
        end
    end

    assign div_wave = odd_fix_i ? (q_p_i & q_n_q) : q_p_i;

    always_comb begin
        if (pass_i) begin
            wave_o = live_n_q ? gen_clk : idle_hi_i;
        end else begin
            wave_o = running_i ? div_wave : idle_hi_i;
        end
    end

    assign status_o = running_i | live_n_q;

endmodule

// File: rtl/clkgen_slice.sv
module clkgen_slice
    import clkgen_pkg::*;
#(
    parameter int NUM_SRC = 2,
    parameter int SRC_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0] src_clk_i,
    input  logic               rst_i,
    input  logic               cfg_wr_i,
    input  logic [SRC_W-1:0]   cfg_src_i,
    input  logic [DIV_W-1:0]   cfg_div_i,
    input  logic               cfg_binary_i,
    input  logic               cfg_balance_i,
    input  logic               cfg_idle_hi_i,
    input  logic               cfg_pin_en_i,
    input  logic               gen_en_i,
    output logic               gclk_o,
    output logic               pin_o,
    output logic               en_stat_o
);

    logic             gen_clk;
    gen_cfg_t         shadow_q;
    logic [SRC_W-1:0] src_shadow_q;
    logic [SRC_W-1:0] src_sel_q;
    div_plan_t        plan_new;
    div_plan_t        plan_act;
    logic             running_q;
    logic             q_p;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_q;
    logic             idle_hi_q;

    clkgen_src_mux #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_mux (
        .src_clk_i (src_clk_i),
        .sel_i     (src_sel_q),
        .gen_clk_o (gen_clk)
    );

    always_ff @(posedge gen_clk) begin
        if (rst_i) begin
            shadow_q     <= '0;
            src_shadow_q <= '0;
            src_sel_q    <= '0;
        end else begin
            if (cfg_wr_i) begin
                shadow_q.div     <= cfg_div_i;
                shadow_q.binary  <= cfg_binary_i;
                shadow_q.balance <= cfg_balance_i;
                shadow_q.idle_hi <= cfg_idle_hi_i;
                shadow_q.pin_en  <= cfg_pin_en_i;
                src_shadow_q     <= cfg_src_i;
            end
            if (!running_q) begin
                src_sel_q <= src_shadow_q;
            end
        end
    end

    assign plan_new  = plan_of(shadow_q);
    assign idle_hi_q = shadow_q.idle_hi;
    assign last_q    = plan_act.last;

    clkgen_div_core u_core (
        .gen_clk    (gen_clk),
        .rst_i      (rst_i),
        .en_i       (gen_en_i),
        .plan_new_i (plan_new),
        .running_o  (running_q),
        .q_p_o      (q_p),
        .plan_o     (plan_act),
        .cnt_o      (cnt_q)
    );

    clkgen_shaper u_shape (
        .gen_clk   (gen_clk),
        .rst_i     (rst_i),
        .running_i (running_q),
        .q_p_i     (q_p),
        .pass_i    (plan_act.pass),
        .odd_fix_i (plan_act.odd_fix),
        .idle_hi_i (idle_hi_q),
        .wave_o    (gclk_o),
        .status_o  (en_stat_o)
    );

    assign pin_o = shadow_q.pin_en & gclk_o;

endmodule

// File: rtl/clkgen_slice_chk.sv
module clkgen_slice_chk
    import clkgen_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             cfg_wr,
    input logic             gclk,
    input logic             stat,
    input logic             idle_hi,
    input logic             running,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] last
);

    assert_idle_level_R5: assert property (@(posedge clk) disable iff (rst)
        !stat |-> (gclk == idle_hi));

    assert_stop_on_boundary_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(running) |-> $past(cnt == last));

    assert_status_needs_off_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(stat) |-> !$past(en));

    assert_write_keeps_run_R7: assert property (@(posedge clk) disable iff (rst)
        (running && en && cfg_wr) |=> running);

    assert_count_in_period_R8: assert property (@(posedge clk) disable iff (rst)
        running |-> (cnt <= last));

endmodule

bind clkgen_slice clkgen_slice_chk u_chk (
    .clk     (gen_clk),
    .rst     (rst_i),
    .en      (gen_en_i),
    .cfg_wr  (cfg_wr_i),
    .gclk    (gclk_o),
    .stat    (en_stat_o),
    .idle_hi (idle_hi_q),
    .running (running_q),
    .cnt     (cnt_q),
    .last    (last_q)
);

// File: tb/clkgen_slice_test.sv
`timescale 1ns/1ps
module clkgen_slice_test;

    localparam real T0 = 10.0;
    localparam real T1 = 16.0;

    logic       clk0 = 1'b0;
    logic       clk1 = 1'b0;
    logic [1:0] src_clk;
    logic       rst = 1'b1;
    logic       cfg_wr = 1'b0;
    logic [0:0] cfg_src = '0;
    logic [7:0] cfg_div = '0;
    logic       cfg_bin = 1'b0;
    logic       cfg_bal = 1'b0;
    logic       cfg_hi = 1'b0;
    logic       cfg_oe = 1'b0;
    logic       gen_en = 1'b0;
    logic       gclk_o;
    logic       pin_o;
    logic       en_stat_o;

    int total = 0;
    int bad = 0;
    int cur_src = 0;

    always #5 clk0 = ~clk0;   // 100 MHz
    always #8 clk1 = ~clk1;
    assign src_clk = {clk1, clk0};

    clkgen_slice uut (
        .src_clk_i     (src_clk),
        .rst_i         (rst),
        .cfg_wr_i      (cfg_wr),
        .cfg_src_i     (cfg_src),
        .cfg_div_i     (cfg_div),
        .cfg_binary_i  (cfg_bin),
        .cfg_balance_i (cfg_bal),
        .cfg_idle_hi_i (cfg_hi),
        .cfg_pin_en_i  (cfg_oe),
        .gen_en_i      (gen_en),
        .gclk_o        (gclk_o),
        .pin_o         (pin_o),
        .en_stat_o     (en_stat_o)
    );

    function automatic int exp_n(bit bin, int div);
        if (bin) return 1 << (div + 1);
        return (div < 2) ? 1 : div;
    endfunction

    function automatic real exp_hi(bit bin, int div, bit bal, real t);
        int n = exp_n(bin, div);
        if (n == 1) return t / 2.0;
        if (!bin && bal && (n % 2 == 1)) return n * t / 2.0;
        return (n / 2) * t;
    endfunction

    function automatic bit near(real a, real b);
        return (a - b < 0.01) && (b - a < 0.01);
    endfunction

    task automatic chk(bit ok, string req, string what, real act, real expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0f expected=%0f", req, what, act, expv);
        end
    endtask

    task automatic negsrc();
        if (cur_src == 1) @(negedge clk1);
        else @(negedge clk0);
    endtask

    task automatic write_cfg(int src, int div, bit bin, bit bal, bit hi, bit oe);
        negsrc();
        cfg_src = 1'(src);
        cfg_div = 8'(div);
        cfg_bin = bin;
        cfg_bal = bal;
        cfg_hi  = hi;
        cfg_oe  = oe;
        cfg_wr  = 1'b1;
        negsrc();
        cfg_wr  = 1'b0;
    endtask

    task automatic stop_gen();
        negsrc();
        gen_en = 1'b0;
        wait (en_stat_o == 1'b0);
        #1;
    endtask

    task automatic start_gen(int src);
        #60;
        cur_src = src;
        negsrc();
        gen_en = 1'b1;
    endtask

    task automatic measure(output real per, output real hi);
        realtime r0, f0, r1;
        @(posedge gclk_o);
        @(posedge gclk_o);
        r0 = $realtime;
        @(negedge gclk_o);
        f0 = $realtime;
        @(posedge gclk_o);
        r1 = $realtime;
        per = r1 - r0;
        hi  = f0 - r0;
    endtask

    task automatic run_case(string req, int src, int div, bit bin, bit bal);
        real per, hi, t;
        stop_gen();
        write_cfg(src, div, bin, bal, 1'b0, 1'b1);
        start_gen(src);
        measure(per, hi);
        t = (src == 1) ? T1 : T0;
        chk(near(per, exp_n(bin, div) * t), req, "period", per, exp_n(bin, div) * t);
        chk(near(hi, exp_hi(bin, div, bal, t)), req, "high time", hi, exp_hi(bin, div, bal, t));
    endtask

    initial begin
        #3_000_000;
        bad++;
        total++;
        $display("FAIL watchdog R6 actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        real per, hi, t0, t1, t2;
        bit ok;
        void'($urandom(32'h00c1_0c6e));
        #100;
        negsrc();
        rst = 1'b0;
        #20;
        // R5: reset state
        chk(en_stat_o == 1'b0, "R5", "reset status", en_stat_o, 0);
        chk(gclk_o == 1'b0, "R5", "reset clock level", gclk_o, 0);
        chk(pin_o == 1'b0, "R5", "reset pin level", pin_o, 0);

        // R5: idle level follows the idle bit while stopped
        write_cfg(0, 4, 1'b0, 1'b0, 1'b1, 1'b0);
        #50;
        chk(gclk_o == 1'b1, "R5", "idle high", gclk_o, 1);
        write_cfg(0, 4, 1'b0, 1'b0, 1'b0, 1'b0);
        #50;
        chk(gclk_o == 1'b0, "R5", "idle low", gclk_o, 0);

        // R3: passthrough for DIV 0 and 1
        run_case("R3", 0, 0, 1'b0, 1'b0);
        run_case("R3", 0, 1, 1'b0, 1'b1);
        // R1: binary mode
        run_case("R1", 0, 0, 1'b1, 1'b0);
        run_case("R1", 0, 3, 1'b1, 1'b1);
        // R2: integer mode, odd and even
        run_case("R2", 0, 5, 1'b0, 1'b0);
        run_case("R2", 0, 6, 1'b0, 1'b0);
        // R4: balanced odd and even
        run_case("R4", 0, 5, 1'b0, 1'b1);
        run_case("R4", 0, 3, 1'b0, 1'b1);
        run_case("R4", 0, 8, 1'b0, 1'b1);
        // R10: second source
        run_case("R10", 1, 3, 1'b0, 1'b0);
        run_case("R10", 0, 3, 1'b0, 1'b0);

        // R6: stop completes the current period
        stop_gen();
        write_cfg(0, 5, 1'b0, 1'b0, 1'b0, 1'b1);
        start_gen(0);
        @(posedge gclk_o);
        @(posedge gclk_o);
        t0 = $realtime;
        negsrc();
        gen_en = 1'b0;
        @(posedge clk0);
        #1;
        chk(en_stat_o == 1'b1, "R6", "status after enable drop", en_stat_o, 1);
        @(negedge en_stat_o);
        t1 = $realtime;
        chk(near(t1 - t0, 5 * T0), "R6", "stop time", t1 - t0, 5 * T0);
        ok = 1'b1;
        for (int i = 0; i < 20; i++) begin
            #7;
            if (gclk_o !== 1'b0) ok = 1'b0;
        end
        chk(ok, "R6", "output rests after stop", ok, 1);

        // R7 and R8: rewrite while running
        write_cfg(0, 4, 1'b0, 1'b0, 1'b0, 1'b1);
        start_gen(0);
        @(posedge gclk_o);
        @(posedge gclk_o);
        t0 = $realtime;
        write_cfg(0, 6, 1'b0, 1'b0, 1'b0, 1'b1);
        @(posedge gclk_o);
        t1 = $realtime;
        chk(near(t1 - t0, 4 * T0), "R8", "period in progress", t1 - t0, 4 * T0);
        #1;
        chk(en_stat_o == 1'b1, "R7", "running after write", en_stat_o, 1);
        @(posedge gclk_o);
        t2 = $realtime;
        chk(near(t2 - t1, 6 * T0), "R8", "new period", t2 - t1, 6 * T0);

        // R9: pin enable
        write_cfg(0, 6, 1'b0, 1'b0, 1'b0, 1'b0);
        #20;
        ok = 1'b1;
        negsrc();
        #1;
        for (int i = 0; i < 20; i++) begin
            if (pin_o !== 1'b0) ok = 1'b0;
            #10;
        end
        chk(ok, "R9", "pin held low", ok, 1);
        chk(en_stat_o == 1'b1, "R7", "running after pin write", en_stat_o, 1);
        write_cfg(0, 6, 1'b0, 1'b0, 1'b0, 1'b1);
        #20;
        ok = 1'b1;
        negsrc();
        #1;
        for (int i = 0; i < 20; i++) begin
            if (pin_o !== gclk_o) ok = 1'b0;
            #10;
        end
        chk(ok, "R9", "pin follows clock", ok, 1);

        // random mix across R1 R2 R3 R4 R10
        for (int k = 0; k < 24; k++) begin
            int s = int'($urandom % 2);
            bit b = 1'($urandom % 2);
            bit l = 1'($urandom % 2);
            int d = b ? int'($urandom % 4) : int'($urandom % 12);
            run_case("R2", s, d, b, l);
        end

        stop_gen();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule